// File: doc/BRIEF.md
# Serial-Programmed Clock Output Gating

This block sits beside a one-input, fourteen-output clock fan-out buffer. It decides which copies of the reference clock reach the pins. A write-only two-wire serial slave with one fixed address receives up to three data bytes. Selected bits of those bytes become one enable flag per output. A gate stage then passes the reference clock to every enabled output. It holds every disabled output low.

The block samples the serial clock and data lines on the system clock, after a synchronizer. It acknowledges by pulling the data line low, and the top drives that pull as an open-drain request. An output-enable pin overrides everything: while it is low, every output is released to high impedance. Enable changes are applied only while the reference clock is low, so a switched output never shows a shortened pulse.

Top module: `clk_fanout_gate`

## Requirements
- R1: The slave acknowledges, by pulling the data line low during the ninth serial clock, only the address byte whose upper seven bits are 1101001 and whose least significant (direction) bit is 0. Bits arrive most significant first.
- R2: After an acknowledged address, data bytes are taken as byte 0, then byte 1, then byte 2. Each byte arrives bit 7 first.
- R3: After reset every enable flag is 1, so with the output-enable pin high every output follows the reference clock.
- R4: Byte 0 bits 0..3 set the enables of outputs 0..3. Bit 6 sets output 4 and bit 7 sets output 5.
- R5: Byte 1 bits 0 and 1 set outputs 6 and 7. Bits 4..7 set outputs 8..11.
- R6: Byte 2 bit 6 sets output 12 and bit 7 sets output 13. Byte 0 bits 4..5, byte 1 bits 2..3 and byte 2 bits 0..5 are reserved and change no output.
- R7: While the output-enable pin is low, every output enable (`clk_oe_o`) is 0, whatever the flags hold. While it is high, every `clk_oe_o` bit is 1.
- R8: An output whose flag is 0 is driven low and stays low. An output whose flag is 1 equals the reference clock.
- R9: A new flag value reaches its output only at a system clock edge where the reference clock is sampled low.
- R10: Every data byte after an acknowledged address is acknowledged, including a fourth and later byte. A byte after byte 2 changes no output.
- R11: A start condition (data falling while the serial clock is high) restarts the sequence at the address byte and byte 0. A byte cut short by a stop or start before its eighth bit is not applied.
- R12: After an address that does not match, or that carries direction bit 1, the slave acknowledges nothing and applies nothing until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_pull_o | output | 1 | High while the slave pulls the data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| oe_pin_i | input | 1 | Global output enable; low releases all outputs |
| clk_out_o | output | 14 | Gated clock copies |
| clk_oe_o | output | 14 | Per-output drive enable; 0 means high impedance |

## Verification
Two functions can fall in the same cycle. One is the commit of a freshly received byte into the enable flags. The other is the gate stage's choice, at each edge, of whether the reference clock is low enough to take a new flag. The bench runs the reference clock independently of the serial traffic, so commits land in both reference phases, across many random transfers. It judges each case by reading the outputs only in the high and low phases after settling, against a bench-side flag model. Directed cases cover a truncated byte, a repeated start, a wrong or read address, bytes past the third, reserved bits and a low output-enable pin.

// File: rtl/clk_fanout_gate_pkg.sv
package clk_fanout_gate_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2,
        RX_SKIP = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] idx;
        logic [7:0] data;
    } byte_commit_t;

    // Which received byte carries the enable for a given output (3 = none).
    function automatic logic [1:0] src_byte(input int unsigned out_n);
        if (out_n < 6)       return 2'd0;
        else if (out_n < 12) return 2'd1;
        else if (out_n < 14) return 2'd2;
        else                 return 2'd3;
    endfunction

    // Bit position within that byte.
    function automatic logic [2:0] src_bit(input int unsigned out_n);
        case (out_n)
            0, 1, 2, 3:    return 3'(out_n);
            4:             return 3'd6;
            5:             return 3'd7;
            6:             return 3'd0;
            7:             return 3'd1;
            8, 9, 10, 11:  return 3'(out_n - 4);
            12:            return 3'd6;
            13:            return 3'd7;
            default:       return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fg_line_sync.sv
module fg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/fg_serial_rx.sv
module fg_serial_rx
    import clk_fanout_gate_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b1101001,
    parameter int         NUM_BYTES  = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scl_lvl,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         sda_lvl,
    input  logic         sda_rise,
    input  logic         sda_fall,
    output logic         sda_pull_o,
    output byte_commit_t commit_o
);
    localparam logic [1:0] LAST_IDX = 2'(NUM_BYTES);

    rx_state_e  state_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q;
    logic [1:0] byte_idx_q;
    logic [7:0] full_byte;
    logic       start_det;
    logic       stop_det;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign full_byte = {shreg_q[6:0], sda_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            byte_idx_q <= '0;
            sda_pull_o <= 1'b0;
            commit_o   <= '0;
        end else begin
            commit_o.valid <= 1'b0;
            if (start_det) begin
                state_q    <= RX_ADDR;
                bitcnt_q   <= '0;
                byte_idx_q <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                state_q    <= RX_IDLE;
                bitcnt_q   <= '0;
                sda_pull_o <= 1'b0;
            end else if (state_q != RX_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt_q < 4'd8) begin
                        shreg_q  <= full_byte;
                        bitcnt_q <= bitcnt_q + 4'd1;
                        if (bitcnt_q == 4'd7) begin
                            if (state_q == RX_ADDR) begin
                                if (full_byte[7:1] != SLAVE_ADDR || full_byte[0])
                                    state_q <= RX_SKIP;
                            end else if (state_q == RX_DATA) begin
                                if (byte_idx_q < LAST_IDX) begin
                                    commit_o.valid <= 1'b1;
                                    commit_o.idx   <= byte_idx_q;
                                    commit_o.data  <= full_byte;
                                    byte_idx_q     <= byte_idx_q + 2'd1;
                                end
                            end
                        end
                    end else if (bitcnt_q == 4'd8) begin
                        bitcnt_q <= 4'd9;
                        if (state_q == RX_ADDR) state_q <= RX_DATA;
                    end
                end else if (scl_fall) begin
                    if (bitcnt_q == 4'd8 && state_q != RX_SKIP) begin
                        sda_pull_o <= 1'b1;
                    end else if (bitcnt_q == 4'd9) begin
                        bitcnt_q   <= '0;
                        sda_pull_o <= 1'b0;
                    end
                end
            end
        end
    end

    p_ack_window_r1: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> (bitcnt_q >= 4'd8));

    p_skip_silent_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_SKIP) |-> !sda_pull_o);

    p_commit_bound_r10: assert property (@(posedge clk) disable iff (rst)
        commit_o.valid |-> (commit_o.idx < LAST_IDX));

    p_start_clears_r11: assert property (@(posedge clk) disable iff (rst)
        $past(start_det) |-> (byte_idx_q == 2'd0 && bitcnt_q == 4'd0 && !commit_o.valid));
endmodule

// File: rtl/fg_enable_regs.sv
module fg_enable_regs
    import clk_fanout_gate_pkg::*;
#(
    parameter int NUM_OUT = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  byte_commit_t       commit_i,
    output logic [NUM_OUT-1:0] en_o
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_flag
        localparam logic [1:0] BYTE_SEL = src_byte(i);
        localparam logic [2:0] BIT_SEL  = src_bit(i);
        always_ff @(posedge clk) begin
            if (rst)
                en_o[i] <= 1'b1;
            else if (commit_i.valid && commit_i.idx == BYTE_SEL)
                en_o[i] <= commit_i.data[BIT_SEL];
        end
    end

    p_reset_on_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_o == '1));
endmodule

// File: rtl/fg_gate_bank.sv
module fg_gate_bank #(
    parameter int NUM_OUT = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_clk_i,
    input  logic               oe_pin_i,
    input  logic [NUM_OUT-1:0] en_i,
    output logic [NUM_OUT-1:0] clk_out_o,
    output logic [NUM_OUT-1:0] clk_oe_o
);
    logic [NUM_OUT-1:0] gate_q;

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= '1;
        else if (!ref_clk_i)
            gate_q <= en_i;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign clk_out_o[i] = oe_pin_i & ref_clk_i & gate_q[i];
        assign clk_oe_o[i]  = oe_pin_i;
    end

    p_no_change_high_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ref_clk_i) |-> $stable(gate_q));
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
    import clk_fanout_gate_pkg::*;
#(
    parameter int         NUM_OUT     = 14,
    parameter int         NUM_BYTES   = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLAVE_ADDR  = 7'b1101001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic               ref_clk_i,
    input  logic               oe_pin_i,
    output logic [NUM_OUT-1:0] clk_out_o,
    output logic [NUM_OUT-1:0] clk_oe_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_line, lvl, rise, fall;
    byte_commit_t         commit;
    logic [NUM_OUT-1:0]   en_flags;

    assign raw_line = {sda_i, scl_i};

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_sync
        fg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .line_i(raw_line[k]),
            .level_o(lvl[k]), .rise_o(rise[k]), .fall_o(fall[k])
        );
    end

    fg_serial_rx #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_BYTES(NUM_BYTES)) u_rx (
        .clk(clk), .rst(rst),
        .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .sda_pull_o(sda_pull_o), .commit_o(commit)
    );

    fg_enable_regs #(.NUM_OUT(NUM_OUT)) u_regs (
        .clk(clk), .rst(rst), .commit_i(commit), .en_o(en_flags)
    );

    fg_gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk(clk), .rst(rst), .ref_clk_i(ref_clk_i), .oe_pin_i(oe_pin_i),
        .en_i(en_flags), .clk_out_o(clk_out_o), .clk_oe_o(clk_oe_o)
    );

    p_low_phase_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !ref_clk_i |-> (clk_out_o == '0));
endmodule

// File: tb/clk_fanout_gate_bench.sv
module clk_fanout_gate_bench;
    localparam int N = 14;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic ref_clk = 1'b0;
    logic oe_pin = 1'b1;
    logic sda_pull;
    logic [N-1:0] clk_out, clk_oe;
    wire  sda_line = sda_m & ~sda_pull;

    int tests = 0;
    int fails = 0;
    int ref_cnt = 0;
    logic [N-1:0] model;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (ref_cnt == 4) begin ref_cnt <= 0; ref_clk <= ~ref_clk; end
        else ref_cnt <= ref_cnt + 1;
    end

    clk_fanout_gate u_clk_fanout_gate (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .ref_clk_i(ref_clk), .oe_pin_i(oe_pin), .clk_out_o(clk_out), .clk_oe_o(clk_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of the byte-to-output map (R4, R5, R6).
    function automatic logic [N-1:0] apply(input logic [N-1:0] m, input int idx, input logic [7:0] d);
        logic [N-1:0] r = m;
        if (idx == 0) begin
            r[0] = d[0]; r[1] = d[1]; r[2] = d[2]; r[3] = d[3]; r[4] = d[6]; r[5] = d[7];
        end else if (idx == 1) begin
            r[6] = d[0]; r[7] = d[1]; r[8] = d[4]; r[9] = d[5]; r[10] = d[6]; r[11] = d[7];
        end else if (idx == 2) begin
            r[12] = d[6]; r[13] = d[7];
        end
        return r;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_m = 1'b1; wait_cyc(H);
        scl = 1'b1;   wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl = 1'b0;   wait_cyc(2);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wait_cyc(H);
        scl = 1'b1;   wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_bits(input logic [7:0] d, input int nbits);
        for (int b = 7; b > 7 - nbits; b--) begin
            sda_m = d[b]; wait_cyc(H);
            scl = 1'b1;   wait_cyc(H);
            scl = 1'b0;   wait_cyc(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        send_bits(d, 8);
        sda_m = 1'b1; wait_cyc(H);
        scl = 1'b1;   wait_cyc(H / 2);
        ack = (sda_line === 1'b0);
        wait_cyc(H / 2);
        scl = 1'b0;   wait_cyc(2);
    endtask

    task automatic check_ack(input string req, input bit act, input bit exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s ack actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        wait_cyc(14);
        while (ref_clk !== 1'b1) @(negedge clk);
        check(req, clk_out, oe_pin ? model : '0);
        check({req, " R7"}, clk_oe, oe_pin ? '1 : '0);
        while (ref_clk !== 1'b0) @(negedge clk);
        check({req, " R8 low phase"}, clk_out, '0);
    endtask

    // Full write transfer; returns through model update when addressed.
    task automatic write_seq(input logic [7:0] addr_byte, input logic [7:0] d[], input string req);
        bit ack;
        bit hit = (addr_byte == 8'hD2);
        start_cond();
        send_byte(addr_byte, ack);
        check_ack({req, " R1/R12 address"}, ack, hit);
        foreach (d[k]) begin
            send_byte(d[k], ack);
            check_ack({req, " R10 data"}, ack, hit);
            if (hit) model = apply(model, k, d[k]);
        end
        stop_cond();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[];
        bit ack;
        void'($urandom(32'd2718));
        wait_cyc(5);
        rst = 1'b0;
        model = '1;
        check_outs("R3 reset all enabled");

        d = new[1]; d[0] = 8'h00;
        write_seq(8'hD2, d, "R4 byte0 clear");
        check_outs("R4 byte0 clear");
        d = new[1]; d[0] = 8'b1000_0101;
        write_seq(8'hD2, d, "R4 byte0 pattern");
        check_outs("R4 byte0 pattern");

        d = new[2]; d[0] = 8'hFF; d[1] = 8'b0101_0010;
        write_seq(8'hD2, d, "R2 R5 byte1 pattern");
        check_outs("R5 byte1 pattern");

        d = new[3]; d[0] = 8'h30; d[1] = 8'h0C; d[2] = 8'h3F;
        write_seq(8'hD2, d, "R6 reserved only");
        check_outs("R6 reserved bits no effect");
        d = new[3]; d[0] = 8'hCF; d[1] = 8'hF3; d[2] = 8'h40;
        write_seq(8'hD2, d, "R6 byte2");
        check_outs("R6 byte2 pattern");

        d = new[5]; d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h80; d[3] = 8'h00; d[4] = 8'h00;
        write_seq(8'hD2, d, "R10 extra bytes");
        check_outs("R10 bytes past third discarded");

        d = new[2]; d[0] = 8'h00; d[1] = 8'h00;
        write_seq(8'hD4, d, "R12 wrong address");
        check_outs("R12 wrong address ignored");
        write_seq(8'hD3, d, "R12 read direction");
        check_outs("R12 read bit ignored");

        start_cond();
        send_byte(8'hD2, ack);
        check_ack("R11 addr", ack, 1'b1);
        send_bits(8'h00, 4);
        stop_cond();
        check_outs("R11 incomplete byte not applied");

        start_cond();
        send_byte(8'hD2, ack);
        send_byte(8'hFF, ack);
        model = apply(model, 0, 8'hFF);
        start_cond();
        send_byte(8'hD2, ack);
        check_ack("R11 repeated start addr", ack, 1'b1);
        send_byte(8'h0A, ack);
        model = apply(model, 0, 8'h0A);
        stop_cond();
        check_outs("R11 repeated start restarts at byte 0");

        oe_pin = 1'b0;
        check_outs("R7 output enable low");
        oe_pin = 1'b1;
        check_outs("R7 output enable restored");

        for (int t = 0; t < 30; t++) begin
            int nb = 1 + ($urandom % 5);
            logic [7:0] ab = (($urandom % 4) == 0) ? 8'($urandom) : 8'hD2;
            d = new[nb];
            foreach (d[k]) d[k] = 8'($urandom);
            oe_pin = (($urandom % 5) != 0);
            write_seq(ab, d, "R2 random");
            check_outs("R8 R9 random transfer");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule